// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the bus-facing front end of a multi-channel event timer. It decodes a 32-bit-only register port with a 10-bit byte address. It holds the read-only capability word and the global configuration (run enable and legacy-routing mode). It also keeps the shared 64-bit up-counter that every channel compares against. The counter advances on pulses of a tick-enable input while the timer runs. Clearing the run enable stops it on the value it holds, and setting the enable again continues counting from there.

Channel registers are not stored here. The block decodes the channel window area into a channel index and a word index and sends out a one-hot write strobe with the write data. Reads of a channel window are served from a read-data input that the addressed channel supplies. When software stops the timer, the block pulses a disarm signal so that the channels drop their pending events and interrupts. Comparator arithmetic and interrupt routing belong to the channels and are not part of this block.

Top module: `evtmr_regfile`

## Requirements
- R1: After reset the counter is 0, the run enable and legacy mode are 0, and no channel write strobe or disarm pulse is asserted.
- R2: The capability word is read-only. Its low word at 0x000 has the revision (parameter REV) in bits 7:0, the channel count minus one in bits 12:8, a 1 in bit 13 (64-bit counter) and a 1 in bit 15 (legacy routing available), with all other bits 0. Its high word at 0x004 is the tick period in femtoseconds (parameter PERIOD_FS). Writes to either word leave both unchanged.
- R3: The configuration low word at 0x010 has run enable in bit 0 and legacy mode in bit 1. A write updates only those bits, and every other bit reads 0. The high word at 0x014 reads 0 and ignores writes.
- R4: While the run enable is 1, the counter rises by exactly one for each clock cycle in which tickEn is high, and the carry passes from the low half into the high half.
- R5: While the run enable is 0, tickEn has no effect. When the enable is set again, counting continues from the value that was held.
- R6: The counter low half is written at 0x0F0 and the high half at 0x0F4. Each write replaces only its own half. A counter write takes precedence over a tick in the same cycle.
- R7: An aligned access in 0x100..0x3FF selects channel (addr-0x100)/32 and word ((addr-0x100) mod 32)/4 on chanSel and chanWord. If the channel is implemented, a write asserts only that bit of chanWrStb, in the same cycle, with busWData on chanWrData. A read returns chanRdData.
- R8: A channel index equal to or greater than NCH reads 0 and asserts no write strobe.
- R9: A configuration write that changes the run enable from 1 to 0 pulses chanDisarm in that same cycle. No other write pulses it.
- R10: A misaligned address (addr[1:0] not 0) or an unassigned offset below 0x100 reads 0, and a write to it changes no state and asserts no strobe.
- R11: Reads of 0x0F0 and 0x0F4 return the low and high halves of the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance qualifier, one tick per high cycle |
| busAddr | input | 10 | Byte address of the access |
| busWr | input | 1 | Write request for the current cycle |
| busWData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| counter | output | 64 | Main counter value |
| gEnable | output | 1 | Run enable |
| legacyMode | output | 1 | Legacy routing mode |
| chanSel | output | 5 | Decoded channel index |
| chanWord | output | 3 | Decoded word within the channel window |
| chanWrStb | output | NCH | One-hot channel write strobe |
| chanWrData | output | 32 | Data for channel writes |
| chanRdData | input | 32 | Read word from the addressed channel |
| chanDisarm | output | 1 | One-cycle pulse when the run enable falls |

## Verification
A wrong decode in this block shows up at the ports in the same cycle as the access: a wrong read word, a strobe on the wrong channel, or a strobe where none belongs. A full sweep of every byte address, for both reads and writes, catches it. A wrong counter or configuration state appears one clock after the write or tick that caused it, as a wrong counter read or a changed enable output. The frozen-counter and write-priority cases are checked by running ticks and then reading the counter halves back.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W = 2 * DATA_W;
  localparam int IDX_W = 5;
  localparam int WORD_W = 3;
  localparam int MAX_CHAN = 24;

  localparam logic [ADDR_W-1:0] OFF_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_CFG_LO = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_CFG_HI = 10'h014;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] CHAN_BASE = 10'h100;
  localparam logic [IDX_W-1:0] CHAN_BASE_IDX = 5'd8;

  localparam logic [1:0] CFG_WR_MASK = 2'b11;
  localparam int CFG_RUN_BIT = 0;
  localparam int CFG_LEG_BIT = 1;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CAP_LO, RD_CAP_HI, RD_CFG, RD_CNT_LO, RD_CNT_HI, RD_CHAN
  } rdSel_e;

  typedef struct packed {
    logic cfgWr;
    logic cntLoWr;
    logic cntHiWr;
    logic chanWr;
    rdSel_e rdSel;
  } ctrlStb_t;
endpackage

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
  import evtmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output ctrlStb_t          stb,
  output logic [IDX_W-1:0]  chanSel,
  output logic [WORD_W-1:0] chanWord
);
  logic aligned;
  logic inChan;
  logic idxValid;
  logic wrOk;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign inChan   = (busAddr >= CHAN_BASE);
  assign chanSel  = busAddr[ADDR_W-1:5] - CHAN_BASE_IDX;
  assign chanWord = busAddr[4:2];
  assign idxValid = inChan && (32'(chanSel) < NCH);
  assign wrOk     = busWr && aligned;

  always_comb begin
    stb = '0;
    stb.rdSel = RD_ZERO;
    if (aligned) begin
      if (inChan) begin
        if (idxValid) stb.rdSel = RD_CHAN;
      end else begin
        case (busAddr)
          OFF_CAP_LO: stb.rdSel = RD_CAP_LO;
          OFF_CAP_HI: stb.rdSel = RD_CAP_HI;
          OFF_CFG_LO: stb.rdSel = RD_CFG;
          OFF_CNT_LO: stb.rdSel = RD_CNT_LO;
          OFF_CNT_HI: stb.rdSel = RD_CNT_HI;
          default:    stb.rdSel = RD_ZERO;
        endcase
      end
    end
    stb.cfgWr   = wrOk && (busAddr == OFF_CFG_LO);
    stb.cntLoWr = wrOk && (busAddr == OFF_CNT_LO);
    stb.cntHiWr = wrOk && (busAddr == OFF_CNT_HI);
    stb.chanWr  = wrOk && idxValid;
  end
endmodule

// File: rtl/evtmr_datapath.sv
module evtmr_datapath
  import evtmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter logic [7:0] REV = 8'h01,
  parameter logic [DATA_W-1:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] busWData,
  input  logic [IDX_W-1:0]  chanSel,
  input  logic [DATA_W-1:0] chanRdData,
  output logic [DATA_W-1:0] busRdData,
  output logic [CNT_W-1:0]  counter,
  output logic              gEnable,
  output logic              legacyMode,
  output logic [NCH-1:0]    chanWrStb,
  output logic              chanDisarm
);
  localparam logic [4:0] NCH_M1 = 5'(NCH - 1);
  localparam logic [DATA_W-1:0] CAP_LO = {16'h0, 1'b1, 1'b0, 1'b1, NCH_M1, REV};

  logic [1:0]       cfgQ;
  logic [1:0]       cfgNext;
  logic [CNT_W-1:0] cntQ;

  assign cfgNext = (busWData[1:0] & CFG_WR_MASK) | (cfgQ & ~CFG_WR_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ <= '0;
    end else if (stb.cfgWr) begin
      cfgQ <= cfgNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (stb.cntLoWr) begin
      cntQ <= {cntQ[CNT_W-1:DATA_W], busWData};
    end else if (stb.cntHiWr) begin
      cntQ <= {busWData, cntQ[DATA_W-1:0]};
    end else if (cfgQ[CFG_RUN_BIT] && tickEn) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign counter    = cntQ;
  assign gEnable    = cfgQ[CFG_RUN_BIT];
  assign legacyMode = cfgQ[CFG_LEG_BIT];
  assign chanDisarm = stb.cfgWr && cfgQ[CFG_RUN_BIT] && !busWData[CFG_RUN_BIT];

  for (genvar i = 0; i < NCH; i++) begin : g_stb
    assign chanWrStb[i] = stb.chanWr && (chanSel == IDX_W'(i));
  end

  always_comb begin
    case (stb.rdSel)
      RD_CAP_LO: busRdData = CAP_LO;
      RD_CAP_HI: busRdData = PERIOD_FS;
      RD_CFG:    busRdData = {30'h0, cfgQ};
      RD_CNT_LO: busRdData = cntQ[DATA_W-1:0];
      RD_CNT_HI: busRdData = cntQ[CNT_W-1:DATA_W];
      RD_CHAN:   busRdData = chanRdData;
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/evtmr_regfile.sv
module evtmr_regfile
  import evtmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter logic [7:0] REV = 8'h01,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tickEn,
  input  logic [9:0]  busAddr,
  input  logic        busWr,
  input  logic [31:0] busWData,
  output logic [31:0] busRdData,
  output logic [63:0] counter,
  output logic        gEnable,
  output logic        legacyMode,
  output logic [4:0]  chanSel,
  output logic [2:0]  chanWord,
  output logic [NCH-1:0] chanWrStb,
  output logic [31:0] chanWrData,
  input  logic [31:0] chanRdData,
  output logic        chanDisarm
);
  ctrlStb_t stb;

  evtmr_ctrl #(.NCH(NCH)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .stb(stb),
    .chanSel(chanSel), .chanWord(chanWord)
  );

  evtmr_datapath #(.NCH(NCH), .REV(REV), .PERIOD_FS(PERIOD_FS)) u_dp (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .stb(stb),
    .busWData(busWData), .chanSel(chanSel), .chanRdData(chanRdData),
    .busRdData(busRdData), .counter(counter), .gEnable(gEnable),
    .legacyMode(legacyMode), .chanWrStb(chanWrStb), .chanDisarm(chanDisarm)
  );

  assign chanWrData = busWData;
endmodule

// File: rtl/evtmr_checker.sv
module evtmr_checker
  import evtmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tickEn,
  input logic [9:0]     busAddr,
  input logic           busWr,
  input logic [31:0]    busRdData,
  input logic [63:0]    counter,
  input logic           gEnable,
  input logic [NCH-1:0] chanWrStb,
  input logic           chanDisarm
);
  logic cntWrite;
  assign cntWrite = busWr && (busAddr == OFF_CNT_LO || busAddr == OFF_CNT_HI);

  AST_CNT_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    gEnable && tickEn && !cntWrite |=> counter == $past(counter) + 64'd1); // R4
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !gEnable && !cntWrite |=> $stable(counter)); // R5
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    busWr && busAddr == OFF_CNT_LO |=> counter[63:32] == $past(counter[63:32])); // R6
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chanWrStb)); // R7
  AST_STB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|chanWrStb) |-> busWr && busAddr >= CHAN_BASE && busAddr[1:0] == 2'b00); // R10
  AST_DISARM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    chanDisarm |-> gEnable && busWr && busAddr == OFF_CFG_LO); // R9
  AST_DISARM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    chanDisarm |=> !gEnable); // R9
  AST_CFG_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busAddr == OFF_CFG_HI |-> busRdData == 32'h0); // R3
endmodule

bind evtmr_regfile evtmr_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .busAddr(busAddr), .busWr(busWr),
  .busRdData(busRdData), .counter(counter), .gEnable(gEnable),
  .chanWrStb(chanWrStb), .chanDisarm(chanDisarm)
);

// File: tb/test_evtmr_regfile.sv
module test_evtmr_regfile;
  localparam int NCH = 5;
  localparam logic [31:0] CAPLO_EXP = 32'h0000_A401;
  localparam logic [31:0] CAPHI_EXP = 32'd10_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0;
  logic [9:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRdData;
  logic [63:0] counter;
  logic gEnable, legacyMode, chanDisarm;
  logic [4:0] chanSel;
  logic [2:0] chanWord;
  logic [NCH-1:0] chanWrStb;
  logic [31:0] chanWrData;
  logic [31:0] chanRdData;

  int checks = 0;
  int errors = 0;
  logic [NCH-1:0] stbCap;
  logic disarmCap;
  logic [31:0] wdCap;
  logic [2:0] wordCap;

  always #5 clk = ~clk;

  assign chanRdData = {8'hA5, 3'b0, chanSel, 13'b0, chanWord};

  evtmr_regfile #(.NCH(NCH)) i_evtmr_regfile (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .busAddr(busAddr), .busWr(busWr),
    .busWData(busWData), .busRdData(busRdData), .counter(counter),
    .gEnable(gEnable), .legacyMode(legacyMode), .chanSel(chanSel),
    .chanWord(chanWord), .chanWrStb(chanWrStb), .chanWrData(chanWrData),
    .chanRdData(chanRdData), .chanDisarm(chanDisarm)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int a, input logic [1:0] cfg, input logic [63:0] cnt);
    if (a % 4 != 0) return 32'h0;
    if (a >= 256) begin
      int idx = (a - 256) / 32;
      int wd = ((a - 256) % 32) / 4;
      if (idx < NCH) return {8'hA5, 3'b0, 5'(idx), 13'b0, 3'(wd)};
      return 32'h0;
    end
    case (a)
      'h000: return CAPLO_EXP;
      'h004: return CAPHI_EXP;
      'h010: return {30'h0, cfg};
      'h0F0: return cnt[31:0];
      'h0F4: return cnt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic busRead(input int a, output logic [31:0] d);
    @(negedge clk);
    busAddr = 10'(a);
    #1 d = busRdData;
  endtask

  task automatic busWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    busAddr = 10'(a);
    busWData = d;
    busWr = 1'b1;
    #1;
    stbCap = chanWrStb;
    disarmCap = chanDisarm;
    wdCap = chanWrData;
    wordCap = chanWord;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic readCnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    busRead('h0F0, lo);
    busRead('h0F4, hi);
    v = {hi, lo};
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    logic [63:0] base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 counter", counter, 64'h0);
    check("R1 enable", {63'h0, gEnable}, 64'h0);
    check("R1 legacy", {63'h0, legacyMode}, 64'h0);
    check("R1 strobes", 64'(chanWrStb), 64'h0);
    check("R1 disarm", {63'h0, chanDisarm}, 64'h0);

    // R2 R3 R7 R8 R10 R11 read sweep over all byte addresses
    for (int a = 0; a < 1024; a++) begin
      busRead(a, d);
      check("R7/R8/R10 read sweep", {22'h0, 10'(a), d}, {22'h0, 10'(a), expRead(a, 2'b00, 64'h0)});
    end

    // R2 capability writes ignored
    busWrite('h000, 32'hFFFF_FFFF);
    busWrite('h004, 32'h1234_5678);
    busRead('h000, d); check("R2 cap lo", 64'(d), 64'(CAPLO_EXP));
    busRead('h004, d); check("R2 cap hi", 64'(d), 64'(CAPHI_EXP));

    // R3 config merge and high word
    busWrite('h010, 32'hFFFF_FFFE);
    check("R3 legacy set", {62'h0, legacyMode, gEnable}, 64'h2);
    busRead('h010, d); check("R3 cfg read", 64'(d), 64'h2);
    busWrite('h014, 32'hFFFF_FFFF);
    busRead('h014, d); check("R3 cfg hi", 64'(d), 64'h0);
    check("R3 cfg hi no effect", {62'h0, legacyMode, gEnable}, 64'h2);
    busWrite('h010, 32'h0);
    check("R9 no pulse when halted", {63'h0, disarmCap}, 64'h0);

    // R6 counter halves
    busWrite('h0F0, 32'hFFFF_FFFF);
    busWrite('h0F4, 32'h0000_0012);
    readCnt(v); check("R6 halves", v, 64'h12_FFFF_FFFF);
    busWrite('h0F0, 32'h5);
    readCnt(v); check("R6 lo only", v, 64'h12_0000_0005);
    busWrite('h0F4, 32'h77);
    readCnt(v); check("R6 hi only", v, 64'h77_0000_0005);
    busWrite('h0F0, 32'hFFFF_FFFF);
    busWrite('h0F4, 32'h12);

    // R4 counting with carry
    busWrite('h010, 32'h1);
    check("R9 no pulse on start", {63'h0, disarmCap}, 64'h0);
    ticks(1);
    readCnt(v); check("R4 carry", v, 64'h13_0000_0000);
    ticks(4);
    readCnt(v); check("R4 single ticks", v, 64'h13_0000_0004);
    @(negedge clk); tickEn = 1'b1;
    repeat (3) @(negedge clk);
    tickEn = 1'b0;
    readCnt(v); check("R4 burst ticks", v, 64'h13_0000_0007);
    repeat (4) @(negedge clk);
    readCnt(v); check("R11 no tick no change", v, 64'h13_0000_0007);

    // R9 disarm then R5 freeze/resume
    busWrite('h010, 32'h2);
    check("R9 disarm pulse", {63'h0, disarmCap}, 64'h1);
    check("R9 enable low", {62'h0, legacyMode, gEnable}, 64'h2);
    ticks(5);
    readCnt(v); check("R5 frozen", v, 64'h13_0000_0007);
    busWrite('h010, 32'h1);
    ticks(2);
    readCnt(v); check("R5 resume", v, 64'h13_0000_0009);

    // R6 write beats tick in same cycle
    @(negedge clk);
    busAddr = 10'h0F0; busWData = 32'h100; busWr = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    busWr = 1'b0; tickEn = 1'b0;
    readCnt(v); check("R6 write priority", v, 64'h13_0000_0100);

    // R7 R8 R10 write sweep with halted timer
    busWrite('h010, 32'h0);
    base = 64'h0123_4567_89AB_CDEF;
    busWrite('h0F0, base[31:0]);
    busWrite('h0F4, base[63:32]);
    for (int a = 0; a < 1024; a++) begin
      logic [NCH-1:0] expStb;
      if (a == 'h010 || a == 'h0F0 || a == 'h0F4) continue;
      expStb = '0;
      if (a >= 256 && a % 4 == 0 && (a - 256) / 32 < NCH) expStb[(a - 256) / 32] = 1'b1;
      busWrite(a, 32'hFFFF_FFFF ^ 32'(a));
      check("R7/R8/R10 write strobe", {22'h0, 10'(a), 32'(stbCap)}, {22'h0, 10'(a), 32'(expStb)});
      if (expStb != '0) begin
        check("R7 write data", 64'(wdCap), 64'(32'hFFFF_FFFF ^ 32'(a)));
        check("R7 word index", 64'(wordCap), 64'(((a - 256) % 32) / 4));
      end
      check("R10 state kept", {counter[62:0], gEnable | legacyMode}, {base[62:0], 1'b0});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule